// File: doc/BRIEF.md
# Serial Converter Capture and Tri-State Latch

This block sits behind an 8-bit converter that sends its result serially, one bit per bit-clock period, while its active-low select is held low. Each select window is ten bit periods long. The first bit and the tenth bit of the window are not valid, so the block keeps only the eight bits in between. It assembles those bits into a parallel word and loads the word into a holding register when the select is released. The holding register keeps its value until the next window ends.

The held byte goes onto a data bus that a memory also drives during readback. The block drives that bus only while the user's capture request is active and the converter select is low. At every other time the bus pins are released to high impedance, and all eight bits are driven or released together. The bit clock is given as a one-cycle enable on the system clock. Debouncing of the request input is done elsewhere.

Top module: `serial_capture_latch`

## Requirements
- R1: After reset `held_byte` is 0 and `bus_drive_en` is 0, and no load happens until a select window has closed.
- R2: A serial bit is taken only on a clock edge where `bit_en` is 1 and `conv_sel_n` is 0. Window positions count from 0 and restart each time `conv_sel_n` goes high. Toggling `ser_bit` while `bit_en` is 0 has no effect.
- R3: Bits arrive MSB first. Window position 1 carries byte bit 7, position 2 carries bit 6, and so on down to position 8, which carries bit 0.
- R4: Bits in position 0, in position 9, and in any position after 9 are discarded. They never reach `held_byte`.
- R5: `held_byte` loads the assembled word on the first clock edge that samples `conv_sel_n` high after it was low. At every other edge it keeps its value, and it is always unchanged at an edge that samples `conv_sel_n` low.
- R6: `bus_drive_en` is 1 in the cycle after an edge that samples `cap_req`=1 and `conv_sel_n`=0. It is 0 in the cycle after an edge where either condition fails, so it drops within one clock of the request being released.
- R7: While `bus_drive_en` is 1, all eight bits of `bus_data` equal `held_byte`. While it is 0, all eight bits are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse marking each serial bit period |
| conv_sel_n | input | 1 | Converter select, active low, framing one window |
| ser_bit | input | 1 | Serial data from the converter |
| cap_req | input | 1 | User capture request, active high |
| held_byte | output | 8 | Byte held from the last completed window |
| bus_drive_en | output | 1 | High while the block drives the shared bus |
| bus_data | inout | 8 | Shared data bus, high impedance when not driven |

## Verification
The bench uses the default configuration: 8 data bits, one lead bit, one tail bit, and MSB-first order. With only 256 possible data words, it sends every value once. For each value it sets the junk bits in positions 0 and 9 to the opposite of their neighbouring data bits, so a position that is off by one shows up as a wrong byte. Some windows carry extra trailing bits. The serial input is toggled between enable pulses. Request windows are mixed into the sweep so that bus drive, release, and holding of the previous byte during a window are each seen many times.

// File: rtl/scl_pkg.sv
package scl_pkg;
   // width of a counter that must hold values 0..n
   function automatic int scl_cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic {
      SCL_LSB_FIRST = 1'b0,
      SCL_MSB_FIRST = 1'b1
   } scl_order_e;
endpackage

// File: rtl/scl_frame_ctr.sv
module scl_frame_ctr #(
   parameter int LEAD_BITS = 1,
   parameter int DATA_BITS = 8,
   parameter int TAIL_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic sel_n,
   output logic shift_en
);
   import scl_pkg::*;

   localparam int WIN_LEN = LEAD_BITS + DATA_BITS + TAIL_BITS;
   localparam int PW      = scl_cnt_w(WIN_LEN);
   localparam logic [PW-1:0] POS_FIRST = PW'(LEAD_BITS);
   localparam logic [PW-1:0] POS_END   = PW'(LEAD_BITS + DATA_BITS);
   localparam logic [PW-1:0] POS_SAT   = PW'(WIN_LEN);

   logic [PW-1:0] pos_q;
   logic          take_bit;

   assign take_bit = bit_en && !sel_n;
   assign shift_en = take_bit && (pos_q >= POS_FIRST) && (pos_q < POS_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (sel_n) begin
         pos_q <= '0;
      end else if (take_bit && (pos_q < POS_SAT)) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   // R4: position counter never runs past the window length
   assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= POS_SAT);

   // R2: position restarts whenever select is released
   assert_pos_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> (pos_q == '0));
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
   parameter int            DATA_BITS = 8,
   parameter scl_pkg::scl_order_e ORDER = scl_pkg::SCL_MSB_FIRST
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 ser_bit,
   output logic [DATA_BITS-1:0] word
);
   logic [DATA_BITS-1:0] sreg_q;
   logic [DATA_BITS-1:0] sreg_d;

   generate
      if (ORDER == scl_pkg::SCL_MSB_FIRST) begin : g_msb
         assign sreg_d = {sreg_q[DATA_BITS-2:0], ser_bit};
      end else begin : g_lsb
         assign sreg_d = {ser_bit, sreg_q[DATA_BITS-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (shift_en) begin
         sreg_q <= sreg_d;
      end
   end

   assign word = sreg_q;

   // R2: shift register only moves on an accepted bit
   assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sreg_q));
endmodule

// File: rtl/scl_hold_latch.sv
module scl_hold_latch #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic [DATA_BITS-1:0] word,
   output logic [DATA_BITS-1:0] held
);
   logic                 sel_prev_q;
   logic                 sel_rise;
   logic [DATA_BITS-1:0] held_q;

   assign sel_rise = sel_n && !sel_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev_q <= 1'b1;
         held_q     <= '0;
      end else begin
         sel_prev_q <= sel_n;
         if (sel_rise) begin
            held_q <= word;
         end
      end
   end

   assign held = held_q;

   // R5: holding register is frozen while the window is open
   assert_hold_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |=> $stable(held_q));

   // R5: two consecutive high samples of select never reload
   assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && sel_prev_q) |=> $stable(held_q));
endmodule

// File: rtl/scl_bus_drive.sv
module scl_bus_drive #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_req,
   input  logic                 sel_n,
   input  logic [DATA_BITS-1:0] held,
   output logic                 drive_en,
   inout  wire  [DATA_BITS-1:0] bus
);
   logic drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
      end else begin
         drive_q <= cap_req && !sel_n;
      end
   end

   // one enable for the whole byte: all bits drive or release together
   assign bus      = drive_q ? held : {DATA_BITS{1'bz}};
   assign drive_en = drive_q;

   // R6: released request turns the driver off within one clock
   assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_req |=> !drive_q);

   // R6: an idle converter select never leaves the bus driven
   assert_sel_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !drive_q);
endmodule

// File: rtl/serial_capture_latch.sv
module serial_capture_latch #(
   parameter int DATA_BITS = 8,
   parameter int LEAD_BITS = 1,
   parameter int TAIL_BITS = 1,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 conv_sel_n,
   input  logic                 ser_bit,
   input  logic                 cap_req,
   output logic [DATA_BITS-1:0] held_byte,
   output logic                 bus_drive_en,
   inout  wire  [DATA_BITS-1:0] bus_data
);
   import scl_pkg::*;

   localparam scl_order_e ORDER = MSB_FIRST ? SCL_MSB_FIRST : SCL_LSB_FIRST;

   generate
      if (DATA_BITS < 2) begin : g_bad_width
         $error("serial_capture_latch: DATA_BITS must be at least 2");
      end
      if (LEAD_BITS < 0 || TAIL_BITS < 0) begin : g_bad_frame
         $error("serial_capture_latch: LEAD_BITS and TAIL_BITS must not be negative");
      end
   endgenerate

   logic                 shift_en;
   logic [DATA_BITS-1:0] word;

   scl_frame_ctr #(
      .LEAD_BITS (LEAD_BITS),
      .DATA_BITS (DATA_BITS),
      .TAIL_BITS (TAIL_BITS)
   ) frame_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .sel_n    (conv_sel_n),
      .shift_en (shift_en)
   );

   scl_shifter #(
      .DATA_BITS (DATA_BITS),
      .ORDER     (ORDER)
   ) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .ser_bit  (ser_bit),
      .word     (word)
   );

   scl_hold_latch #(
      .DATA_BITS (DATA_BITS)
   ) latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_n (conv_sel_n),
      .word  (word),
      .held  (held_byte)
   );

   scl_bus_drive #(
      .DATA_BITS (DATA_BITS)
   ) drive_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_req  (cap_req),
      .sel_n    (conv_sel_n),
      .held     (held_byte),
      .drive_en (bus_drive_en),
      .bus      (bus_data)
   );

   // R7: driven bus always carries the held byte
   assert_bus_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive_en |-> (bus_data == held_byte));

   // R1: no drive during the first cycle after reset release
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive_en) |-> $past(cap_req && !conv_sel_n));
endmodule

// File: tb/serial_capture_latch_tb.sv
module serial_capture_latch_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       conv_sel_n = 1'b1;
   logic       ser_bit = 1'b0;
   logic       cap_req = 1'b0;
   logic [7:0] held_byte;
   logic       bus_drive_en;
   wire  [7:0] bus_data;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  cycles   = 0;
   bit  done     = 1'b0;
   logic [7:0] prev = 8'h00;

   always #2 clk = ~clk;

   serial_capture_latch dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_en       (bit_en),
      .conv_sel_n   (conv_sel_n),
      .ser_bit      (ser_bit),
      .cap_req      (cap_req),
      .held_byte    (held_byte),
      .bus_drive_en (bus_drive_en),
      .bus_data     (bus_data)
   );

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one select window: junk in position 0 and 9, extra trailing bits
   task automatic run_win(input logic [7:0] b, input logic j0, input logic j9,
                          input int extra, input bit req);
      @(negedge clk);
      cap_req    = req;
      conv_sel_n = 1'b0;
      for (int k = 0; k < 10 + extra; k++) begin
         logic v;
         if (k == 0)      v = j0;
         else if (k == 9) v = j9;
         else if (k > 9)  v = ~j9 ^ k[0];
         else             v = b[8-k];
         @(negedge clk);
         ser_bit = v;
         bit_en  = 1'b1;
         @(negedge clk);
         bit_en  = 1'b0;
         ser_bit = ~v;          // R2: toggles without enable are ignored
         if (k == 5) begin
            check("R5 held during window", {1'b0, held_byte}, {1'b0, prev});
            check("R6 drive in window", {8'h00, bus_drive_en}, {8'h00, req});
            if (req)
               check("R7 bus value", {1'b0, bus_data}, {1'b0, prev});
         end
      end
      @(negedge clk);
      conv_sel_n = 1'b1;
      @(negedge clk);
      check("R3 R4 captured byte", {1'b0, held_byte}, {1'b0, b});
      check("R6 release on select high", {8'h00, bus_drive_en}, 9'h000);
      cap_req = 1'b0;
      prev = b;
   endtask

   initial begin
      fork
         begin
            while (!done && cycles < 150000) begin
               @(posedge clk);
               cycles++;
            end
            if (!done) begin
               n_checks++;
               n_fail++;
               $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
               $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
               $finish;
            end
         end
      join_none

      repeat (3) @(negedge clk);
      check("R1 reset held", {1'b0, held_byte}, 9'h000);
      check("R1 reset drive", {8'h00, bus_drive_en}, 9'h000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 no load before window", {1'b0, held_byte}, 9'h000);

      // R6: request with select high never drives
      cap_req = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 request without select", {8'h00, bus_drive_en}, 9'h000);
      cap_req = 1'b0;

      // exhaustive sweep over data values
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = i[7:0];
         run_win(b, ~b[7], ~b[0], i % 3, (i % 8) == 3);
      end

      // R6: release request mid-window, drive must drop in one clock
      @(negedge clk);
      cap_req    = 1'b1;
      conv_sel_n = 1'b0;
      @(negedge clk);
      check("R6 drive on", {8'h00, bus_drive_en}, 9'h001);
      check("R7 bus value on", {1'b0, bus_data}, {1'b0, prev});
      cap_req = 1'b0;
      @(negedge clk);
      check("R6 drive off after release", {8'h00, bus_drive_en}, 9'h000);
      conv_sel_n = 1'b1;
      @(negedge clk);
      // empty window: shift register unchanged, reload gives the same byte
      check("R5 reload empty window", {1'b0, held_byte}, {1'b0, prev});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule